// File: doc/BRIEF.md
# Eight-Channel Timer Pin Driver

This block turns per-channel timer interrupt pulses into eight output pin levels. Each channel has a mode. In master mode the channel flips its own pin on each of its own pulses. In slave mode the pin is pulled high by the pulse of a chosen master channel and pulled low by the channel's own pulse. A timer that counts a period on the master and a duty on the slave therefore yields a PWM or one-shot waveform. The counters that raise the pulses, the bus decode and the pin multiplexing are outside this block.

Software writes a 16-bit mode word, either in full or only its low byte. Bit `n` holds the requested mode of channel `n` (0 = master, 1 = slave). A requested mode does not act at once. Each channel holds an active mode of its own, and it takes on the requested mode only at its next output event while its enable is high. That event is still handled under the old mode. A 3-bit select per channel names its master. Only even channels below the slave may be named. An invalid name blocks the set path.

Each channel is a small state machine. The pin states are `PIN_LOW` and `PIN_HIGH`, with the transitions *toggle* (LOW↔HIGH), *set* (LOW→HIGH) and *clear* (HIGH→LOW). The active-mode states are `MODE_MASTER` and `MODE_SLAVE`, with the single transition *adopt*, which loads the requested mode at any toggle, set or clear event.

Top module: `tmo_outctl`

## Requirements
- R1: After reset the mode word reads 0x0000, all pins are 0 and every channel's active mode is master.
- R2: Mode word bit 0 and bits 15 to 8 always read 0, and writes to them have no effect.
- R3: A write with `wr_wide`=1 loads bits 7..1 from `wr_data[7:1]`. A write with `wr_wide`=0 loads only the low byte from `wr_data[7:0]`. The result is visible on `mode_rd` one cycle later.
- R4: A channel whose active mode is master and whose enable is 1 toggles its pin on the clock edge that samples its own pulse.
- R5: A channel whose active mode is slave and whose enable is 1 goes high on its master's pulse and low on its own pulse.
- R6: A changed mode bit takes effect only after the channel's next toggle, set or clear event while enabled. That event is handled under the previous active mode.
- R7: A channel with `out_en[n]`=0 keeps its pin level, ignores all pulses and keeps its active mode.
- R8: When a slave's master pulse and own pulse arrive in the same cycle, the pin ends low.
- R9: Slave channel `n` is paired with its master through `msel[3n+2:3n]`. A select that is odd, or not below `n`, blocks the set path, and the own pulse still clears the pin.
- R10: Channel 0 always acts as a master, whatever is written to the mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Mode word write strobe |
| wr_wide | input | 1 | 1 = full 16-bit write, 0 = low byte only |
| wr_data | input | 16 | Write data |
| mode_rd | output | 16 | Current mode word |
| out_en | input | 8 | Per-channel output enable |
| irq | input | 8 | Per-channel single-cycle interrupt pulses |
| msel | input | 24 | Master select, 3 bits per channel |
| pin | output | 8 | Pin levels |

## Verification
The hardest situation to reach is a channel whose requested mode and active mode differ, because the active mode has no port of its own. The bench gets there by writing a new mode bit and then firing the master's pulse. A pin that does not react to that pulse shows the old mode is still in force. The bench then fires the channel's own pulse, which must toggle the pin rather than clear it, and sends a further master pulse to show the adoption took place. The same-cycle set and clear case is reached by pulsing master and slave together, both from a low pin and from a high pin.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
    typedef enum logic {PIN_LOW, PIN_HIGH} pin_state_e;
    typedef enum logic {MODE_MASTER, MODE_SLAVE} out_mode_e;
endpackage

// File: rtl/tmo_modereg.sv
module tmo_modereg #(
    parameter int REGW  = 16,
    parameter int BYTEW = 8,
    parameter int NCH   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_wide,
    input  logic [REGW-1:0] wr_data,
    output logic [REGW-1:0] mode_rd,
    output logic [NCH-1:0]  mode_bits
);
    // writable bits: 1 .. NCH-1; bit 0 and everything above are reserved
    localparam logic [REGW-1:0] WMASK =
        ((REGW'(1) << NCH) - REGW'(1)) & ~REGW'(1);

    logic [REGW-1:0] word_q;
    logic [REGW-1:0] word_d;

    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            if (wr_wide)
                word_d = wr_data & WMASK;
            else
                word_d = {word_q[REGW-1:BYTEW], wr_data[BYTEW-1:0]} & WMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_q <= '0;
        else
            word_q <= word_d;
    end

    always_comb begin
        mode_rd   = word_q;
        mode_bits = word_q[NCH-1:0];
    end
endmodule

// File: rtl/tmo_pair.sv
module tmo_pair #(
    parameter int NCH  = 8,
    parameter int SELW = 3
) (
    input  logic [NCH-1:0]      irq,
    input  logic [NCH*SELW-1:0] msel,
    output logic [NCH-1:0]      mst_p
);
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [SELW:0] NIDX = (SELW+1)'(n);
        logic [SELW-1:0] sel;
        logic            legal;
        always_comb begin
            sel   = msel[n*SELW +: SELW];
            legal = (sel[0] == 1'b0) && ({1'b0, sel} < NIDX);
            mst_p[n] = legal && irq[sel];
        end
    end
endmodule

// File: rtl/tmo_chan.sv
module tmo_chan
    import tmo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic own_p,
    input  logic mst_p,
    input  logic mode_req,
    output logic pin
);
    pin_state_e st_q, st_d;
    out_mode_e  md_q, md_d;
    logic is_slave, ev_tog, ev_set, ev_clr, ev_any;

    always_comb begin
        is_slave = (md_q == MODE_SLAVE);
        ev_tog   = en && own_p && !is_slave;
        ev_clr   = en && own_p && is_slave;
        ev_set   = en && mst_p && is_slave;
        ev_any   = ev_tog || ev_clr || ev_set;
    end

    // pin next state: clear outranks set
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PIN_LOW:  if (ev_tog || (ev_set && !ev_clr)) st_d = PIN_HIGH;
            PIN_HIGH: if (ev_tog || ev_clr)              st_d = PIN_LOW;
        endcase
    end

    // active mode: adopt the requested mode on any event
    always_comb begin
        md_d = md_q;
        if (ev_any) md_d = mode_req ? MODE_SLAVE : MODE_MASTER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PIN_LOW;
            md_q <= MODE_MASTER;
        end else begin
            st_q <= st_d;
            md_q <= md_d;
        end
    end

    always_comb pin = (st_q == PIN_HIGH);
endmodule

// File: rtl/tmo_outctl.sv
module tmo_outctl #(
    parameter int NCH   = 8,
    parameter int REGW  = 16,
    parameter int BYTEW = 8,
    parameter int SELW  = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_wide,
    input  logic [REGW-1:0]     wr_data,
    output logic [REGW-1:0]     mode_rd,
    input  logic [NCH-1:0]      out_en,
    input  logic [NCH-1:0]      irq,
    input  logic [NCH*SELW-1:0] msel,
    output logic [NCH-1:0]      pin
);
    logic [NCH-1:0] mode_bits;
    logic [NCH-1:0] mst_p;

    tmo_modereg #(.REGW(REGW), .BYTEW(BYTEW), .NCH(NCH)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide),
        .wr_data(wr_data), .mode_rd(mode_rd), .mode_bits(mode_bits)
    );

    tmo_pair #(.NCH(NCH), .SELW(SELW)) u_pair (
        .irq(irq), .msel(msel), .mst_p(mst_p)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        tmo_chan u_chan (
            .clk(clk), .rst_n(rst_n), .en(out_en[n]), .own_p(irq[n]),
            .mst_p(mst_p[n]), .mode_req(mode_bits[n]), .pin(pin[n])
        );
    end
endmodule

// File: rtl/tmo_outctl_chk.sv
module tmo_outctl_chk #(
    parameter int NCH   = 8,
    parameter int REGW  = 16,
    parameter int BYTEW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [REGW-1:0] wr_data,
    input logic [REGW-1:0] mode_rd,
    input logic [NCH-1:0]  out_en,
    input logic [NCH-1:0]  irq,
    input logic [NCH-1:0]  pin
);
    localparam logic [REGW-1:0] WMASK =
        ((REGW'(1) << NCH) - REGW'(1)) & ~REGW'(1);
    localparam logic [REGW-1:0] LOWM = WMASK & ((REGW'(1) << BYTEW) - REGW'(1));

    function automatic logic [NCH-1:0] even_mask();
        logic [NCH-1:0] m = '0;
        for (int i = 0; i < NCH; i += 2) m[i] = 1'b1;
        return m;
    endfunction
    localparam logic [NCH-1:0] EVENM = even_mask();

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd & ~WMASK) == '0);

    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_rd & LOWM) == ($past(wr_data) & LOWM));

    p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin ^ $past(pin)) & ~$past(out_en)) == '0);

    p_fall_own_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~pin & $past(pin)) & ~$past(irq)) == '0);

    p_rise_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pin & ~$past(pin)) &
                  ~($past(irq) | {NCH{|($past(irq) & EVENM)}})) == '0);

    p_ch0_master_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pin[0] == $past(pin[0])) || $past(irq[0]));
endmodule

bind tmo_outctl tmo_outctl_chk #(.NCH(NCH), .REGW(REGW), .BYTEW(BYTEW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mode_rd(mode_rd), .out_en(out_en), .irq(irq), .pin(pin)
);

// File: tb/tmo_outctl_test.sv
module tmo_outctl_test;
    localparam int NCH = 8, REGW = 16, SELW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, wr_wide = 1'b0;
    logic [REGW-1:0] wr_data = '0;
    logic [REGW-1:0] mode_rd;
    logic [NCH-1:0] out_en = '0, irq = '0, pin;
    logic [NCH*SELW-1:0] msel = '0;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    tmo_outctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide),
        .wr_data(wr_data), .mode_rd(mode_rd), .out_en(out_en), .irq(irq),
        .msel(msel), .pin(pin)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic wide, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_wide = wide; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        @(negedge clk); irq = m;
        @(negedge clk); irq = '0;
    endtask

    task automatic set_sel(input int ch, input logic [SELW-1:0] v);
        @(negedge clk); msel[ch*SELW +: SELW] = v;
    endtask

    task automatic t_reset;
        check("R1 mode word", 32'(mode_rd), 32'h0);
        check("R1 pins", 32'(pin), 32'h0);
    endtask

    task automatic t_register;
        write_mode(1'b1, 16'hFFFF); check("R2 reserved bits", 32'(mode_rd), 32'h00FE);
        write_mode(1'b1, 16'h00AA); check("R3 wide write", 32'(mode_rd), 32'h00AA);
        write_mode(1'b0, 16'hFF55); check("R3 byte write", 32'(mode_rd), 32'h0054);
        write_mode(1'b1, 16'h0000); check("R3 clear", 32'(mode_rd), 32'h0000);
    endtask

    task automatic t_master;
        out_en = '1;
        pulse(8'h04); check("R4 toggle up", 32'(pin), 32'h04);
        pulse(8'h04); check("R4 toggle down", 32'(pin), 32'h00);
        pulse(8'h05); check("R4 two channels", 32'(pin), 32'h05);
        pulse(8'h05); check("R4 two back", 32'(pin), 32'h00);
    endtask

    task automatic t_enable;
        @(negedge clk); out_en = 8'hFE;
        pulse(8'h01); check("R7 ignored while off", 32'(pin), 32'h00);
        @(negedge clk); out_en = 8'hFF;
        pulse(8'h01); check("R7 acts when on", 32'(pin), 32'h01);
        @(negedge clk); out_en = 8'hFE;
        pulse(8'h01); check("R7 holds high", 32'(pin), 32'h01);
        @(negedge clk); out_en = 8'hFF;
        pulse(8'h01); check("R7 resumes", 32'(pin), 32'h00);
    endtask

    task automatic t_deferred;
        set_sel(3, 3'd2);
        write_mode(1'b1, 16'h0008);
        pulse(8'h04); check("R6 old mode ignores master", 32'(pin), 32'h04);
        pulse(8'h08); check("R6 event under old mode toggles", 32'(pin), 32'h0C);
        pulse(8'h08); check("R6 slave clear", 32'(pin), 32'h04);
        pulse(8'h04); check("R6 slave set", 32'(pin), 32'h08);
        pulse(8'h08); check("R6 back low", 32'(pin), 32'h00);
    endtask

    task automatic t_slave;
        pulse(8'h04); check("R5 set by master", 32'(pin), 32'h0C);
        pulse(8'h08); check("R5 cleared by own", 32'(pin), 32'h04);
        pulse(8'h04); check("R5 set again", 32'(pin), 32'h08);
        pulse(8'h08); check("R5 low", 32'(pin), 32'h00);
    endtask

    task automatic t_priority;
        pulse(8'h0C); check("R8 both from low", 32'(pin), 32'h04);
        pulse(8'h04); check("R8 prep high", 32'(pin), 32'h08);
        pulse(8'h0C); check("R8 both from high", 32'(pin), 32'h04);
        pulse(8'h04); pulse(8'h08); check("R8 settle", 32'(pin), 32'h00);
    endtask

    task automatic t_pairing;
        set_sel(5, 3'd3);
        write_mode(1'b1, 16'h0028);
        pulse(8'h20); check("R9 adopt via toggle", 32'(pin), 32'h20);
        pulse(8'h20); check("R9 own clear", 32'(pin), 32'h00);
        pulse(8'h08); check("R9 odd select blocked", 32'(pin), 32'h00);
        set_sel(5, 3'd6);
        pulse(8'h40); check("R9 higher select blocked", 32'(pin), 32'h40);
        pulse(8'h40); check("R9 restore", 32'(pin), 32'h00);
        set_sel(5, 3'd4);
        pulse(8'h10); check("R9 valid select sets", 32'(pin), 32'h30);
        pulse(8'h10); pulse(8'h20); check("R9 settle", 32'(pin), 32'h00);
    endtask

    task automatic t_ch0;
        write_mode(1'b1, 16'hFFFF);
        set_sel(0, 3'd0);
        pulse(8'h01); check("R10 ch0 toggles", 32'(pin), 32'h01);
        pulse(8'h01); check("R10 ch0 toggles back", 32'(pin), 32'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_register;
        t_master;
        t_enable;
        t_deferred;
        t_slave;
        t_priority;
        t_pairing;
        t_ch0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule